// File: doc/BRIEF.md
# Gate-Driver Clock Startup Sequencer

This block is the digital control core of a multi-channel panel gate-clock level shifter. It watches a synchronized "high rail is above its undervoltage limit" flag, a discharge-sense comparator flag and clock input 1. From these it decides, for six clock channels and two discharge outputs, whether each output is held at its low rail, follows its own input, or is forced to the high rail. The analog stage beneath it turns each 2-bit command into a drive level.

While the high rail is below its limit, everything is held low. When the rail comes up, a strap selects one of two release behaviours. In the first, the clock channels pass their inputs through at once. In the second, they stay low until the first rising edge of clock input 1 that arrives after the rail is good. If the discharge-sense flag is not good when the rail comes up, every output is driven high. This fault stays latched until the asynchronous reset. The charge-sharing mode select is captured at the same moment the rail comes up, and it is cleared when the rail drops.

Top module: `gclk_start_seq`

## Requirements
- R1: After the asynchronous reset, every command is 00 and `cs_mode` is 0.
- R2: While the synchronized rail flag is low and no fault is latched, all six clock commands and both discharge commands are 00.
- R3: With `edge_rel` = 0, a rising rail flag while `dsense_ok` is high sets all six clock commands to 01 and keeps both discharge commands at 00.
- R4: With `edge_rel` = 1, the clock commands stay 00 after the rail flag rises. The first rising edge of `clk1_in` after that moves all six to 01 together.
- R5: A rising edge of `clk1_in` that occurs while the rail flag is low does not count as the releasing edge.
- R6: If `dsense_ok` is low when the rail flag rises, all eight commands become 10. They stay 10 when the rail flag later falls, and only the asynchronous reset clears them.
- R7: `cs_mode` takes the value of `cs_sel` at the rising edge of the rail flag. It ignores later changes of `cs_sel` while the flag stays high, and it returns to 0 when the flag falls.
- R8: When the rail flag falls after a release without a fault, all commands return to 00. With `edge_rel` = 1, a fresh `clk1_in` rising edge is then needed after the next rail rise.
- R9: The command encoding is 00 = hold low, 01 = follow input, 10 = force high, and 11 is never produced. Channel i (0-based) occupies bits [2i+1:2i] of `ch_cmd`.
- R10: `uvlo_ok`, `dsense_ok` and `clk1_in` each pass through a two-flop synchronizer. A command responds by the third rising clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset; also clears the fault latch |
| clk1_in | input | 1 | Clock input of channel 1, used to detect the releasing edge |
| uvlo_ok | input | 1 | High-rail undervoltage flag, 1 = rail good |
| dsense_ok | input | 1 | Discharge-sense comparator flag, 1 = above its threshold |
| cs_sel | input | 1 | Charge-sharing mode select |
| edge_rel | input | 1 | Release strap: 0 = release immediately, 1 = wait for a clock-1 edge |
| ch_cmd | output | 12 | Six 2-bit clock-channel drive commands |
| dis1_cmd | output | 2 | Drive command of discharge output 1 |
| dis2_cmd | output | 2 | Drive command of discharge output 2 |
| cs_mode | output | 1 | Latched charge-sharing mode |

## Verification
The hardest situation to reach from the ports is the edge-release variant after a clock-1 edge has already come and gone while the rail was low. Both the early edge and the later rail rise pass through synchronizers, so the stimulus has to place each of them in a separate window. Each random scenario optionally pulses `clk1_in` with the rail flag low, then raises the rail and checks that the outputs are still held. Only after that does it send the releasing pulse. The scenarios also drop the rail and raise it again, so the re-arm and the mode re-capture are checked across that cycle.

// File: rtl/gclk_start_seq.sv
module gclk_start_seq #(
  parameter int NCH         = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk1_in,
  input  logic             uvlo_ok,
  input  logic             dsense_ok,
  input  logic             cs_sel,
  input  logic             edge_rel,
  output logic [2*NCH-1:0] ch_cmd,
  output logic [1:0]       dis1_cmd,
  output logic [1:0]       dis2_cmd,
  output logic             cs_mode
);

  localparam logic [1:0] C_LOW    = 2'b00;
  localparam logic [1:0] C_FOLLOW = 2'b01;
  localparam logic [1:0] C_HIGH   = 2'b10;
  localparam int         TOP      = SYNC_STAGES - 1;

  typedef enum logic [1:0] {S_HOLD, S_WAIT, S_RUN, S_FAULT} st_t;

  logic [TOP:0] uv_sy, ds_sy, c1_sy;
  logic         uv_d, c1_d;
  st_t          st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_sy <= '0;
      ds_sy <= '0;
      c1_sy <= '0;
      uv_d  <= 1'b0;
      c1_d  <= 1'b0;
    end else begin
      uv_sy <= {uv_sy[TOP-1:0], uvlo_ok};
      ds_sy <= {ds_sy[TOP-1:0], dsense_ok};
      c1_sy <= {c1_sy[TOP-1:0], clk1_in};
      uv_d  <= uv_sy[TOP];
      c1_d  <= c1_sy[TOP];
    end
  end

  wire uv_s    = uv_sy[TOP];
  wire ds_s    = ds_sy[TOP];
  wire uv_rise = uv_s & ~uv_d;
  wire c1_rise = c1_sy[TOP] & ~c1_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_HOLD;
    end else if (st != S_FAULT) begin
      if (!uv_s)
        st <= S_HOLD;
      else if (st == S_HOLD && uv_rise)
        st <= !ds_s ? S_FAULT : (edge_rel ? S_WAIT : S_RUN);
      else if (st == S_WAIT && c1_rise)
        st <= S_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cs_mode <= 1'b0;
    else if (!uv_s)   cs_mode <= 1'b0;
    else if (uv_rise) cs_mode <= cs_sel;
  end

  wire [1:0] lane = (st == S_RUN) ? C_FOLLOW : (st == S_FAULT) ? C_HIGH : C_LOW;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign ch_cmd[2*g +: 2] = lane;
      a_r9_no_code11: assert property (@(posedge clk) disable iff (!rst_n)
        ch_cmd[2*g +: 2] != 2'b11);
    end
  endgenerate

  assign dis1_cmd = (st == S_FAULT) ? C_HIGH : C_LOW;
  assign dis2_cmd = dis1_cmd;

  a_r2_held_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_d && st != S_FAULT) |-> (ch_cmd == '0 && dis1_cmd == C_LOW && dis2_cmd == C_LOW));

  a_r6_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (dis1_cmd == C_HIGH) |=> (dis1_cmd == C_HIGH && ch_cmd[1:0] == C_HIGH));

  a_r7_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_d && $past(uv_d)) |-> $stable(cs_mode));

  a_r4_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && uv_s && !c1_rise) |=> (st == S_WAIT && ch_cmd == '0));

  a_r8_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_s && st != S_FAULT) |=> (!cs_mode && st == S_HOLD));

endmodule

// File: tb/sim_gclk_start_seq.sv
`timescale 1ns/1ps
module sim_gclk_start_seq;
  localparam int NCH = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clk1_in = 0, uvlo_ok = 0, dsense_ok = 0, cs_sel = 0, edge_rel = 0;
  logic [2*NCH-1:0] ch_cmd;
  logic [1:0] dis1_cmd, dis2_cmd;
  logic cs_mode;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gclk_start_seq u0 (.clk, .rst_n, .clk1_in, .uvlo_ok, .dsense_ok, .cs_sel, .edge_rel,
                     .ch_cmd, .dis1_cmd, .dis2_cmd, .cs_mode);

  function automatic logic [2*NCH-1:0] rep(input logic [1:0] c);
    return {NCH{c}};
  endfunction

  function automatic logic [1:0] exp_ch(input bit fault, input bit released);
    return fault ? 2'b10 : (released ? 2'b01 : 2'b00);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_c1();
    clk1_in = 1; cyc(4); clk1_in = 0; cyc(4);
  endtask

  task automatic do_reset();
    rst_n = 0; uvlo_ok = 0; clk1_in = 0; cyc(2);
    chk("R1 ch", ch_cmd, '0);
    chk("R1 dis", {dis1_cmd, dis2_cmd}, 4'b0);
    chk("R1 mode", cs_mode, 0);
    rst_n = 1; cyc(2);
  endtask

  task automatic scenario(input bit v, input bit ds, input bit cs, input bit early);
    bit fault;
    edge_rel = v;
    uvlo_ok = 0; cyc(6);
    chk("R2 held ch", ch_cmd, '0);
    chk("R2 held dis", {dis1_cmd, dis2_cmd}, 4'b0);
    if (early) pulse_c1();
    cs_sel = cs; dsense_ok = ds; uvlo_ok = 1;
    cyc(2);
    chk("R10 not yet", ch_cmd, '0);
    cyc(4);
    cs_sel = ~cs; cyc(3);
    fault = !ds;
    chk("R7 mode captured", cs_mode, cs);
    if (fault) begin
      chk("R6 fault ch", ch_cmd, rep(2'b10));
      chk("R6 fault dis", {dis1_cmd, dis2_cmd}, 4'b1010);
    end else if (!v) begin
      chk("R3 immediate", ch_cmd, rep(exp_ch(0, 1)));
      chk("R3 dis low", {dis1_cmd, dis2_cmd}, 4'b0);
    end else begin
      chk(early ? "R5 early edge ignored" : "R4 waiting", ch_cmd, rep(exp_ch(0, 0)));
      pulse_c1();
      chk("R4 released", ch_cmd, rep(exp_ch(0, 1)));
    end
    uvlo_ok = 0; cyc(6);
    chk("R7 mode cleared", cs_mode, 0);
    if (fault) begin
      chk("R6 latched", ch_cmd, rep(2'b10));
      do_reset();
    end else begin
      chk("R8 back low", ch_cmd, '0);
      if (v) begin
        uvlo_ok = 1; cyc(6);
        chk("R8 rearm wait", ch_cmd, '0);
        pulse_c1();
        chk("R8 rearm release", ch_cmd, rep(2'b01));
        uvlo_ok = 0; cyc(6);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    cyc(1);
    do_reset();
    cyc(3);
    chk("R10 exact latency pre", ch_cmd, '0);
    edge_rel = 0; dsense_ok = 1; uvlo_ok = 1;
    @(posedge clk); @(posedge clk); #1;
    chk("R10 two edges held", ch_cmd, '0);
    @(posedge clk); #1;
    chk("R10 third edge", ch_cmd, rep(2'b01));
    cyc(2);
    scenario(0, 1, 1, 0);
    scenario(1, 1, 0, 1);
    scenario(1, 1, 1, 0);
    scenario(0, 0, 1, 0);
    scenario(1, 0, 0, 1);
    for (int i = 0; i < 40; i++)
      scenario($urandom % 2, ($urandom % 4) != 0, $urandom % 2, $urandom % 2);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule